// File: doc/BRIEF.md
# External Bus Handover Controller

This block decides when an external memory bus, with a synchronous DRAM attached, is handed from the internal bus master to an external requester and when it is taken back. An external master asks for the bus by pulling an active-low request line low. The controller lets any external access in progress complete. It then issues a precharge-all command so that no DRAM bank is left open, floats the bus by dropping the output-enable, and grants the bus through an active-low grant output.

While the bus is released the controller keeps watching the request line. When the line goes high it withdraws the grant. It then spends one state driving the strobes to NOP with the outputs enabled before internal traffic resumes. If the return-request feature is enabled and an internal access or a refresh becomes pending during the release, an active-low return-request output asks the external master to give the bus back. That output goes high again a state and a half after the grant rises. If a refresh caused it, it stays low until the refresh cycle starts.

Top module: `ext_bus_handover`

## Requirements
- R1: During and after reset, with no request, the outputs sit at grant_n=1, ret_req_n=1, bus_oe=1 and the NOP command (ras_n=1, cas_n=1, we_n=1).
- R2: ext_req_n passes through a two-stage synchronizer. If it goes low before rising edge 1 and acc_done is high, rising edge 4 drives the precharge-all command (ras_n=0, cas_n=1, we_n=0) with bus_oe=1, and rising edge 5 drives grant_n low.
- R3: While acc_done is low after a request has been seen, the controller holds grant_n=1, bus_oe=1 and NOP. Precharge follows on the first rising edge that samples acc_done high.
- R4: Whenever grant_n is low, bus_oe is low and the strobes read NOP.
- R5: The grant stays low while ext_req_n stays low. After ext_req_n goes high before rising edge 1, grant_n is still low after edge 2 and goes high on edge 3.
- R6: On the edge where grant_n rises, bus_oe returns to 1 with NOP, and the block stays idle (NOP, outputs enabled) on the following state.
- R7: With ret_en=1 and int_acc_req or int_ref_req high while the grant is low, ret_req_n goes low on the falling edge after the first rising edge that samples the request.
- R8: A ret_req_n asserted for an internal access returns high on the falling edge 1.5 states after the rising edge that raises grant_n.
- R9: A ret_req_n asserted for a refresh stays low after the release ends until a rising edge samples ref_start high, and goes high on the falling edge that follows.
- R10: With ret_en=0, ret_req_n stays high whatever internal requests are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_req_n | input | 1 | Active-low bus request from the external master |
| ret_en | input | 1 | Enables the return-request output |
| int_acc_req | input | 1 | Internal master needs an external access |
| int_ref_req | input | 1 | Refresh is pending |
| ref_start | input | 1 | Pulse: the refresh cycle begins |
| acc_done | input | 1 | High when no external access is outstanding |
| grant_n | output | 1 | Active-low bus grant to the external master |
| ret_req_n | output | 1 | Active-low request to return the bus |
| ras_n | output | 1 | DRAM row strobe |
| cas_n | output | 1 | DRAM column strobe |
| we_n | output | 1 | DRAM write enable |
| bus_oe | output | 1 | High: address, data and DRAM strobes are driven |

## Verification
The hardest case to reach is a return request raised for a refresh that must outlive the release. The low level has to survive the grant's rise, the reclaim state and several idle states, and it may fall only half a state after ref_start is sampled. The stimulus keeps int_ref_req high through a whole release, then delays the ref_start pulse for several states. It samples just after rising edges, so the half-state offset of the falling-edge stage shows up as a one-sample lag against a rising-edge output.

// File: rtl/ebh_pkg.sv
package ebh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FINISH  = 3'd1,
    ST_PCHG    = 3'd2,
    ST_REL     = 3'd3,
    ST_RECLAIM = 3'd4
  } ebh_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dram_cmd_t CMD_PALL = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
endpackage

// File: rtl/ebh_sync.sv
module ebh_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ebh_fsm.sv
module ebh_fsm
  import ebh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_act,
  input  logic      acc_done,
  output logic      released,
  output logic      grant_n,
  output logic      bus_oe,
  output dram_cmd_t cmd
);
  ebh_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_act)  state_d = ST_FINISH;
      ST_FINISH:  if (acc_done) state_d = ST_PCHG;
      ST_PCHG:    state_d = ST_REL;
      ST_REL:     if (!req_act) state_d = ST_RECLAIM;
      ST_RECLAIM: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign released = (state_q == ST_REL);
  assign grant_n  = ~released;
  assign bus_oe   = ~released;
  assign cmd      = (state_q == ST_PCHG) ? CMD_PALL : CMD_NOP;

  a_r4_float_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_n |-> (!bus_oe && cmd == CMD_NOP));
  a_r2_pall_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> $past(cmd == CMD_PALL && bus_oe));
  a_r5_hold_while_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_n && req_act) |=> !grant_n);
  a_r6_nop_on_reclaim: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_n) |-> (bus_oe && cmd == CMD_NOP));
endmodule

// File: rtl/ebh_retreq.sv
module ebh_retreq (
  input  logic clk,
  input  logic rst_n,
  input  logic released,
  input  logic ret_en,
  input  logic int_acc_req,
  input  logic int_ref_req,
  input  logic ref_start,
  output logic ret_req_n
);
  logic ask_now;
  logic ref_hold_q, ref_hold_d;
  logic drive_q, drive_d;

  assign ask_now    = released && ret_en;
  assign ref_hold_d = (ref_hold_q || (ask_now && int_ref_req)) && !ref_start;
  assign drive_d    = (ask_now && (int_acc_req || int_ref_req)) || ref_hold_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_hold_q <= 1'b0;
      drive_q    <= 1'b0;
    end else begin
      ref_hold_q <= ref_hold_d;
      drive_q    <= drive_d;
    end
  end

  // half-state retiming stage: the output moves on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ret_req_n <= 1'b1;
    else        ret_req_n <= ~drive_q;
  end

  a_r10_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_en && !ref_hold_q) |=> !drive_q);
  a_r9_refresh_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hold_q && !ref_start) |=> drive_q);
endmodule

// File: rtl/ext_bus_handover.sv
module ext_bus_handover
  import ebh_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req_n,
  input  logic ret_en,
  input  logic int_acc_req,
  input  logic int_ref_req,
  input  logic ref_start,
  input  logic acc_done,
  output logic grant_n,
  output logic ret_req_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic bus_oe
);
  logic      rst_s_n;
  logic      req_n_s;
  logic      released;
  dram_cmd_t cmd;

  ebh_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_s_n)
  );

  ebh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk(clk), .arst_n(rst_s_n), .d(ext_req_n), .q(req_n_s)
  );

  ebh_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .req_act(~req_n_s), .acc_done(acc_done),
    .released(released), .grant_n(grant_n), .bus_oe(bus_oe), .cmd(cmd)
  );

  ebh_retreq u_ret (
    .clk(clk), .rst_n(rst_s_n), .released(released), .ret_en(ret_en),
    .int_acc_req(int_acc_req), .int_ref_req(int_ref_req),
    .ref_start(ref_start), .ret_req_n(ret_req_n)
  );

  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
endmodule

// File: tb/ext_bus_handover_test.sv
module ext_bus_handover_test;
  logic clk = 1'b0;
  logic rst_n, ext_req_n, ret_en, int_acc_req, int_ref_req, ref_start, acc_done;
  logic grant_n, ret_req_n, ras_n, cas_n, we_n, bus_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // observed vector: {grant_n, ret_req_n, bus_oe, ras_n, cas_n, we_n}
  localparam logic [5:0] V_IDLE  = 6'b111_111;
  localparam logic [5:0] V_PALL  = 6'b111_010;
  localparam logic [5:0] V_REL   = 6'b010_111;
  localparam logic [5:0] V_RELRQ = 6'b000_111;
  localparam logic [5:0] V_RQLOW = 6'b101_111;

  always #2 clk = ~clk;

  ext_bus_handover uut (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .ret_en(ret_en),
    .int_acc_req(int_acc_req), .int_ref_req(int_ref_req), .ref_start(ref_start),
    .acc_done(acc_done), .grant_n(grant_n), .ret_req_n(ret_req_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .bus_oe(bus_oe)
  );

  function automatic logic [5:0] obs();
    return {grant_n, ret_req_n, bus_oe, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input string tag, input logic [5:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, obs(), exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ext_req_n = 1'b1; ret_en = 1'b1; int_acc_req = 1'b0;
    int_ref_req = 1'b0; ref_start = 1'b0; acc_done = 1'b1;
    tick(3);
    chk("R1 in reset", V_IDLE);
    @(negedge clk) rst_n = 1'b1;
    tick(4);
    chk("R1 after reset", V_IDLE);
  endtask

  task automatic t_grant(input bit slow_access);
    @(negedge clk);
    ext_req_n = 1'b0;
    if (slow_access) begin
      acc_done = 1'b0;
      tick(3);
      chk("R3 wait for access", V_IDLE);
      tick(2);
      chk("R3 still waiting", V_IDLE);
      @(negedge clk) acc_done = 1'b1;
      tick(1);
      chk("R3 precharge after done", V_PALL);
    end else begin
      tick(3);
      chk("R2 edge 3 no grant", V_IDLE);
      tick(1);
      chk("R2 precharge edge 4", V_PALL);
    end
    tick(1);
    chk("R4 granted and floating", V_REL);
  endtask

  task automatic t_release();
    tick(3);
    chk("R5 held while requested", V_REL);
    @(negedge clk) ext_req_n = 1'b1;
    tick(2);
    chk("R5 grant still low edge 2", V_REL);
    tick(1);
    chk("R6 reclaim nop driven", V_IDLE);
    tick(1);
    chk("R6 idle after reclaim", V_IDLE);
  endtask

  task automatic t_ret_access();
    t_grant(1'b0);
    @(negedge clk) int_acc_req = 1'b1;
    tick(1);
    chk("R7 not yet low", V_REL);
    tick(1);
    chk("R7 return request low", V_RELRQ);
    @(negedge clk) ext_req_n = 1'b1;
    tick(3);
    chk("R8 low at grant rise", V_RQLOW);
    tick(1);
    chk("R8 low one state later", V_RQLOW);
    tick(1);
    chk("R8 high after 1.5 states", V_IDLE);
    @(negedge clk) int_acc_req = 1'b0;
    tick(2);
  endtask

  task automatic t_ret_refresh();
    t_grant(1'b0);
    @(negedge clk) int_ref_req = 1'b1;
    tick(2);
    chk("R7 low for refresh", V_RELRQ);
    @(negedge clk) ext_req_n = 1'b1;
    tick(5);
    chk("R9 held past release", V_RQLOW);
    tick(3);
    chk("R9 held until refresh", V_RQLOW);
    @(negedge clk) begin ref_start = 1'b1; int_ref_req = 1'b0; end
    tick(1);
    chk("R9 still low at start edge", V_RQLOW);
    @(negedge clk) ref_start = 1'b0;
    tick(1);
    chk("R9 high after refresh start", V_IDLE);
  endtask

  task automatic t_disabled();
    ret_en = 1'b0;
    t_grant(1'b0);
    @(negedge clk) begin int_acc_req = 1'b1; int_ref_req = 1'b1; end
    tick(3);
    chk("R10 quiet while released", V_REL);
    @(negedge clk) ext_req_n = 1'b1;
    tick(5);
    chk("R10 quiet after release", V_IDLE);
    @(negedge clk) begin int_acc_req = 1'b0; int_ref_req = 1'b0; ret_en = 1'b1; end
    tick(2);
  endtask

  initial begin
    t_reset();
    t_grant(1'b0);
    t_release();
    t_grant(1'b1);
    t_release();
    t_ret_access();
    t_ret_refresh();
    t_disabled();
    t_grant(1'b0);
    t_release();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule